// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character per request into an asynchronous serial frame on a single output line. The character comes in over a valid/ready handshake. An external baud generator supplies a one-cycle bit tick. The transmitter never measures time itself: it moves to the next bit only when a tick arrives.

Each frame is built from four parts:
- a low start bit;
- the data bits, least significant first;
- an optional parity bit, even or odd;
- one or two high stop bits.

The character length, the parity options and the stop count are sampled together with the data when the request is accepted. They stay fixed until the frame ends, so every frame can use its own format. While the block is sending, it shows a busy flag and does not accept new requests.

A typical 8-bit frame with no parity and one stop bit takes 10 bit times. Two of those ten are framing overhead.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_busy` is 0 and `in_ready` is 1.
- R2: While no frame is in progress, `tx_line` stays at 1 and `bit_tick` pulses have no effect on any output.
- R3: A character is accepted only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the frame ends. A request raised during a frame is ignored and does not change that frame.
- R4: After acceptance the line stays 1 until the next tick. That tick starts exactly one start bit at 0.
- R5: Data bits follow the start bit, bit 0 first. The count of data bits is `cfg_len`, taken as 5 when `cfg_len` is below 5 and as 9 when it is above 9. Data bits above that count are never sent.
- R6: When `cfg_par_en` is 1, a parity bit follows the last data bit and comes before the stop bits. With `cfg_par_odd`=0 it makes the number of ones, over the active data bits and the parity bit together, even. With `cfg_par_odd`=1 that number is odd.
- R7: The frame ends with stop bits at 1: one stop bit when `cfg_two_stop`=0, two when it is 1. `tx_busy` falls only while the line is at 1.
- R8: Each bit lasts exactly one tick period. `tx_line` changes only in the cycle after a cycle in which `bit_tick` was 1.
- R9: Data and all configuration inputs are captured at acceptance. Changing them during a frame does not alter that frame.
- R10: `tx_busy` is 1 from the cycle after acceptance until the cycle after the tick that ends the last stop bit. A frame therefore spans 1 + length + parity + stops tick periods, which is 10 for 8 data bits, no parity and one stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period from the baud generator |
| in_valid | input | 1 | Character request |
| in_ready | output | 1 | Idle; a request in this cycle is accepted |
| in_data | input | MAX_BITS (9) | Character, bit 0 sent first |
| cfg_len | input | LEN_W (4) | Data bit count, clamped to MIN_BITS..MAX_BITS |
| cfg_par_en | input | 1 | 1 appends a parity bit |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| tx_line | output | 1 | Serial output, idle at 1 |
| tx_busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default range of 5 to 9 data bits. It drives the tick every few clocks, so there are idle cycles between bit boundaries. Those gaps let it show that the line holds between ticks and that the block waits for a tick after acceptance. The default range includes both clamp edges, so raw lengths of 3 and 12 check both ends of the length saturation. The 9-bit maximum lets the longest frame run: nine data bits, parity and two stop bits. Masked upper data bits and mid-frame changes to the request and configuration inputs show that only the captured, active bits reach the line.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ARMED  = 3'd1,
    PH_START  = 3'd2,
    PH_DATA   = 3'd3,
    PH_PARITY = 3'd4,
    PH_STOP   = 3'd5
  } phase_e;

  // Saturate a requested character length into the supported window.
  function automatic int unsigned sft_clamp(input int unsigned raw,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (raw < lo)      return lo;
    else if (raw > hi) return hi;
    else               return raw;
  endfunction

endpackage

// File: rtl/sft_parity.sv
module sft_parity #(
  parameter int MAX_BITS = 9,
  parameter int LEN_W    = 4
) (
  input  logic [MAX_BITS-1:0] data,
  input  logic [LEN_W-1:0]    len,
  input  logic                odd,
  output logic                par_bit
);

  // Reduction XOR over the low `n` bits only.
  function automatic logic xor_active(input logic [MAX_BITS-1:0] d,
                                      input logic [LEN_W-1:0] n);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < int'(n)) acc = acc ^ d[i];
    end
    return acc;
  endfunction

  assign par_bit = xor_active(data, len) ^ odd;

endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
  parameter int MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_data,
  input  logic                shift,
  output logic                lsb
);

  logic [MAX_BITS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= load_data;
    else if (shift) sh_q <= {1'b0, sh_q[MAX_BITS-1:1]};
  end

  assign lsb = sh_q[0];

endmodule

// File: rtl/sft_sequencer.sv
module sft_sequencer
  import sft_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             accept,
  input  logic [LEN_W-1:0] len_q,
  input  logic             par_en_q,
  input  logic             two_stop_q,
  output phase_e           ph,
  output logic             shift_en
);

  phase_e           ph_q;
  logic [LEN_W-1:0] idx_q;

  // Named internal events, used by the assertions below.
  logic last_data;
  logic first_stop_extend;
  logic frame_done;

  assign last_data         = (ph_q == PH_DATA) && (idx_q == len_q - LEN_W'(1));
  assign first_stop_extend = (ph_q == PH_STOP) && two_stop_q && (idx_q == '0);
  assign frame_done        = tick && (ph_q == PH_STOP) && !first_stop_extend;
  assign shift_en          = tick && (ph_q == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE:  if (accept) ph_q <= PH_ARMED;
        PH_ARMED: if (tick)   ph_q <= PH_START;
        PH_START: if (tick) begin
          ph_q  <= PH_DATA;
          idx_q <= '0;
        end
        PH_DATA: if (tick) begin
          if (last_data) begin
            ph_q  <= par_en_q ? PH_PARITY : PH_STOP;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + LEN_W'(1);
          end
        end
        PH_PARITY: if (tick) begin
          ph_q  <= PH_STOP;
          idx_q <= '0;
        end
        PH_STOP: if (tick) begin
          if (first_stop_extend) idx_q <= LEN_W'(1);
          else                   ph_q  <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ph = ph_q;

  // R5: the data index never runs past the latched length
  assert_data_index_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA) |-> (idx_q < len_q));

  // R6: the parity slot is reached only when parity was enabled
  assert_parity_only_if_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PARITY) |-> par_en_q);

  // R10: completing the last stop bit returns to idle
  assert_done_goes_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (ph_q == PH_IDLE));

  // R4: acceptance arms the frame without starting it
  assert_accept_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ph_q == PH_IDLE) |=> (ph_q == PH_ARMED));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  output logic                tx_line,
  output logic                tx_busy
);

  phase_e           ph;
  logic             accept;
  logic             shift_en;
  logic             data_bit;
  logic             par_now;
  logic [LEN_W-1:0] len_eff;

  logic [LEN_W-1:0] len_q;
  logic             par_en_q;
  logic             two_stop_q;
  logic             par_q;

  assign in_ready = (ph == PH_IDLE);
  assign tx_busy  = !in_ready;
  assign accept   = in_valid && in_ready;
  assign len_eff  = LEN_W'(sft_clamp(32'(cfg_len), MIN_BITS, MAX_BITS));

  sft_parity #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_parity (
    .data    (in_data),
    .len     (len_eff),
    .odd     (cfg_par_odd),
    .par_bit (par_now)
  );

  // Frame format is captured with the character and held until the end.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q      <= LEN_W'(MIN_BITS);
      par_en_q   <= 1'b0;
      two_stop_q <= 1'b0;
      par_q      <= 1'b0;
    end else if (accept) begin
      len_q      <= len_eff;
      par_en_q   <= cfg_par_en;
      two_stop_q <= cfg_two_stop;
      par_q      <= par_now;
    end
  end

  sft_shifter #(.MAX_BITS(MAX_BITS)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (in_data),
    .shift     (shift_en),
    .lsb       (data_bit)
  );

  sft_sequencer #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (bit_tick),
    .accept     (accept),
    .len_q      (len_q),
    .par_en_q   (par_en_q),
    .two_stop_q (two_stop_q),
    .ph         (ph),
    .shift_en   (shift_en)
  );

  always_comb begin
    case (ph)
      PH_START:  tx_line = 1'b0;
      PH_DATA:   tx_line = data_bit;
      PH_PARITY: tx_line = par_q;
      default:   tx_line = 1'b1;
    endcase
  end

  // R8: the line only moves right after a tick
  assert_line_moves_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(tx_line));

  // R2: mark level whenever no frame is in progress
  assert_idle_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  // R7: the frame closes on a high level
  assert_busy_ends_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> ($past(tx_line) && tx_line));

  // R3: an accepted request makes the block busy while the line still rests
  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tx_busy && tx_line));

  // R9: captured format stays put while busy
  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable({len_q, par_en_q, two_stop_q, par_q}));

endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;

  localparam int MAXB = 9;
  localparam int LW   = 4;
  localparam int NV   = 8;

  // {two_stop, par_odd, par_en, len[3:0], data[8:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'd8,  9'h041},
    {1'b1, 1'b0, 1'b1, 4'd9,  9'h1A5},
    {1'b0, 1'b1, 1'b1, 4'd5,  9'h00F},
    {1'b1, 1'b0, 1'b0, 4'd7,  9'h155},
    {1'b0, 1'b0, 1'b1, 4'd3,  9'h1FF},
    {1'b1, 1'b1, 1'b1, 4'd12, 9'h0B3},
    {1'b0, 1'b0, 1'b1, 4'd6,  9'h1E0},
    {1'b0, 1'b1, 1'b1, 4'd8,  9'h000}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bit_tick = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [MAXB-1:0] in_data = '0;
  logic [LW-1:0]   cfg_len = 4'd8;
  logic            cfg_par_en = 1'b0;
  logic            cfg_par_odd = 1'b0;
  logic            cfg_two_stop = 1'b0;
  logic            tx_line;
  logic            tx_busy;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  serial_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .tx_line(tx_line), .tx_busy(tx_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  // Expected frame, bit 0 sent first; returns the number of tick periods.
  function automatic int build_frame(input logic [8:0] d, input int raw, input bit pe,
                                     input bit odd, input bit two,
                                     output logic [15:0] f, output int nlen);
    int n;
    int ones;
    nlen = (raw < 5) ? 5 : ((raw > 9) ? 9 : raw);
    f = '1;
    f[0] = 1'b0;
    n = 1;
    ones = 0;
    for (int i = 0; i < nlen; i++) begin
      f[n] = d[i];
      if (d[i]) ones++;
      n++;
    end
    if (pe) begin
      f[n] = ((ones % 2) == 1) ? ~odd : odd;
      n++;
    end
    n = n + (two ? 2 : 1);
    return n;
  endfunction

  task automatic send_frame(input logic [15:0] v, input bit disturb);
    logic [15:0] f;
    int nlen;
    int nb;
    string tag;
    nb = build_frame(v[8:0], int'(v[12:9]), v[13], v[14], v[15], f, nlen);
    @(negedge clk);
    check("R3 ready before request", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_data = v[8:0]; cfg_len = v[12:9];
    cfg_par_en = v[13]; cfg_par_odd = v[14]; cfg_two_stop = v[15];
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 busy after accept", 32'(tx_busy), 32'd1);
    check("R4 line held before first tick", 32'(tx_line), 32'd1);
    if (disturb) begin
      in_valid = 1'b1; in_data = ~v[8:0]; cfg_len = 4'd5;
      cfg_par_en = ~v[13]; cfg_par_odd = ~v[14]; cfg_two_stop = ~v[15];
    end
    for (int k = 0; k < nb; k++) begin
      pulse_tick();
      if (k == 0) tag = "R4 start bit";
      else if (k <= nlen) tag = "R5 data bit";
      else if (v[13] && k == nlen + 1) tag = "R6 parity bit";
      else tag = "R7 stop bit";
      check(tag, 32'(tx_line), 32'(f[k]));
      check("R10 busy during frame", 32'(tx_busy), 32'd1);
      if (disturb) check("R3 not ready while busy", 32'(in_ready), 32'd0);
      @(negedge clk);
      check("R8 line held between ticks", 32'(tx_line), 32'(f[k]));
      if (disturb && k == nb - 1) begin
        in_valid = 1'b0;
        cfg_len = v[12:9]; cfg_par_en = v[13]; cfg_par_odd = v[14]; cfg_two_stop = v[15];
      end
    end
    pulse_tick();
    check("R10 busy drops after last stop", 32'(tx_busy), 32'd0);
    check("R7 line high at frame end", 32'(tx_line), 32'd1);
    check("R3 ready after frame", 32'(in_ready), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset line", 32'(tx_line), 32'd1);
    check("R1 reset busy", 32'(tx_busy), 32'd0);
    check("R1 reset ready", 32'(in_ready), 32'd1);

    for (int t = 0; t < 3; t++) begin
      pulse_tick();
      check("R2 idle tick line", 32'(tx_line), 32'd1);
      check("R2 idle tick busy", 32'(tx_busy), 32'd0);
    end

    for (int i = 0; i < NV; i++) send_frame(VEC[i], 1'b0);

    // R9 and R3: request and format inputs are changed mid-frame
    send_frame({1'b0, 1'b1, 1'b1, 4'd9, 9'h12C}, 1'b1);
    pulse_tick();
    check("R3 ignored request started nothing", 32'(tx_busy), 32'd0);
    check("R2 line idle after disturbed frame", 32'(tx_line), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule